// File: doc/BRIEF.md
# Write-Update Coherent Cache Array

The block serves several processor ports that share one backing store. Each port owns a small fully-associative cache. Reads and writes are answered from that cache: a write stays local and marks its entry dirty, and a read that hits returns the cached copy even when that copy is out of date. A background propagation engine makes the dirty values visible to everyone else. It first copies a dirty value into every other cache that holds the same variable, one cache per cycle. Only once all of those copies agree, and are clean, does it write the store and mark the source entry clean.

Each port can also issue two synchronisation requests. A barrier stalls until the whole system is consistent. An unlock stalls only until the requesting port's own cache holds no dirty entry. Every port uses a valid/ready handshake, and a stalled request holds ready low. A read or write is accepted in the cycle in which valid and ready are both high, and read data is valid in that same cycle.

Top module: `coh_update_array`

## Requirements
- R1: After reset every cache is empty and every store word is zero, so a read returns 0 and both barrier and unlock are ready at once.
- R2: An accepted write (op code 1) places the value in the writer's own cache as a dirty entry. A following read from the same port returns the new value, while the store and the other caches keep their old contents until propagation.
- R3: A read (op code 0) that hits returns the cached value even when the store holds a different one.
- R4: A read that misses returns the store word at that address. It allocates a clean entry in the lowest free slot if one exists; otherwise the cache is unchanged.
- R5: A write that misses fills the lowest free slot; failing that, it evicts the lowest clean slot. If every slot is valid and dirty, ready stays low and nothing changes.
- R6: In each cycle the engine takes the lowest dirty entry, ordered by port index first and slot index second. If some other port holds that address with a different value or a dirty state, the engine copies the value as clean into the lowest such port. Otherwise it writes the store and marks the source entry clean. It takes at most one action per cycle.
- R7: When two ports hold dirty copies of one address, the lower port's value is propagated and the other copy is overwritten as clean, so every port then reads the lower port's value.
- R8: In any cycle in which any port has a read or write accepted, the engine takes no action.
- R9: A barrier (op code 2) is ready only when no entry in any cache is dirty and every valid entry equals the store word at its address.
- R10: An unlock (op code 3) is ready exactly when the requesting port's own cache has no dirty entry, whatever the other caches hold.
- R11: A read is always ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NPORT | Request valid, one bit per port |
| req_op | input | 2*NPORT | Operation per port: 0 read, 1 write, 2 barrier, 3 unlock |
| req_addr | input | AW*NPORT | Variable address per port |
| req_wdata | input | DW*NPORT | Write value per port |
| req_ready | output | NPORT | Request accepted this cycle when high together with valid |
| rsp_rdata | output | DW*NPORT | Read value per port, valid in the cycle a read is accepted |

## Verification
The hardest state to reach from the ports is a stale read or a full-dirty stall, because the engine drains dirty entries as soon as traffic stops. The stimulus therefore keeps another port issuing reads every cycle, which holds the engine still. While it is held, the bench observes stale hits, fills a cache with dirty entries until a write stalls, and then releases the ports to watch propagation proceed cycle by cycle. Conflicting same-cycle writes from two ports, followed by reads from both, exercise the ordering rule. A long random phase over a few shared addresses is then compared against the behavioural model on every clock.

// File: rtl/coh_pkg.sv
// Shared definitions for the write-update coherent cache array.
// Assumes: request op codes are fixed and decoded by the top module.
package coh_pkg;
    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_BARRIER = 2'd2,
        OP_UNLOCK  = 2'd3
    } coh_op_e;
endpackage

// File: rtl/coh_store.sv
// Backing store: one word per address, written only by the propagation engine.
// Assumes: the whole array is small enough to expose flat for parallel reads.
module coh_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    output logic [(1<<AW)*DW-1:0]    mem_flat
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Store word update and reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Flatten the array for parallel readers.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_flat[i*DW +: DW] = mem_q[i];
    end
endmodule

// File: rtl/coh_cache_bank.sv
// One port's fully-associative cache: lookup, allocation, and the engine's
// update and clean ports.
// Assumes: the top never asserts a processor write or fill in the same cycle
// as an engine update or clean, and an address lives in at most one slot.
module coh_cache_bank #(
    parameter int SLOTS = 4,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         lk_addr,
    input  logic [DW-1:0]         lk_wdata,
    input  logic [DW-1:0]         lk_fill,
    input  logic                  wr_en,
    input  logic                  fill_en,
    input  logic                  upd_en,
    input  logic [AW-1:0]         upd_addr,
    input  logic [DW-1:0]         upd_data,
    input  logic                  clr_en,
    input  logic [$clog2(SLOTS)-1:0] clr_slot,
    output logic                  hit,
    output logic [DW-1:0]         hit_data,
    output logic                  wr_room,
    output logic                  fill_room,
    output logic                  any_dirty,
    output logic [SLOTS-1:0]      e_valid,
    output logic [SLOTS-1:0]      e_dirty,
    output logic [SLOTS*AW-1:0]   e_addr,
    output logic [SLOTS*DW-1:0]   e_data
);
    localparam int SW = $clog2(SLOTS);

    logic [SLOTS-1:0] valid_q, dirty_q;
    logic [AW-1:0]    addr_q [SLOTS];
    logic [DW-1:0]    data_q [SLOTS];

    logic          free_found, clean_found, upd_hit;
    logic [SW-1:0] hit_slot, free_slot, clean_slot, upd_slot, wr_slot;

    // Lookup for the processor address and the engine address; lowest slot wins.
    always_comb begin
        hit = 1'b0;        hit_slot = '0;
        free_found = 1'b0; free_slot = '0;
        clean_found = 1'b0; clean_slot = '0;
        upd_hit = 1'b0;    upd_slot = '0;
        for (int s = SLOTS-1; s >= 0; s--) begin
            if (valid_q[s] && addr_q[s] == lk_addr) begin
                hit = 1'b1; hit_slot = SW'(s);
            end
            if (!valid_q[s]) begin
                free_found = 1'b1; free_slot = SW'(s);
            end
            if (valid_q[s] && !dirty_q[s]) begin
                clean_found = 1'b1; clean_slot = SW'(s);
            end
            if (valid_q[s] && addr_q[s] == upd_addr) begin
                upd_hit = 1'b1; upd_slot = SW'(s);
            end
        end
        hit_data  = data_q[hit_slot];
        wr_slot   = hit ? hit_slot : (free_found ? free_slot : clean_slot);
        wr_room   = hit | free_found | clean_found;
        fill_room = free_found;
        any_dirty = |dirty_q;
    end

    // Entry state: processor write or fill, engine update, engine clean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int s = 0; s < SLOTS; s++) begin
                addr_q[s] <= '0;
                data_q[s] <= '0;
            end
        end else begin
            if (wr_en) begin
                valid_q[wr_slot] <= 1'b1;
                dirty_q[wr_slot] <= 1'b1;
                addr_q[wr_slot]  <= lk_addr;
                data_q[wr_slot]  <= lk_wdata;
            end else if (fill_en) begin
                valid_q[free_slot] <= 1'b1;
                dirty_q[free_slot] <= 1'b0;
                addr_q[free_slot]  <= lk_addr;
                data_q[free_slot]  <= lk_fill;
            end
            if (upd_en && upd_hit) begin
                data_q[upd_slot]  <= upd_data;
                dirty_q[upd_slot] <= 1'b0;
            end
            if (clr_en) dirty_q[clr_slot] <= 1'b0;
        end
    end

    // Flatten entry state for the engine and the consistency check.
    always_comb begin
        e_valid = valid_q;
        e_dirty = dirty_q;
        for (int s = 0; s < SLOTS; s++) begin
            e_addr[s*AW +: AW] = addr_q[s];
            e_data[s*DW +: DW] = data_q[s];
        end
    end
endmodule

// File: rtl/coh_prop_engine.sv
// Propagation engine: picks the lowest dirty entry and either updates one
// other holder or, when all holders agree clean, writes the store.
// Assumes: the decision is recomputed from current state every cycle, and
// hold suppresses any action in cycles with processor reads or writes.
module coh_prop_engine #(
    parameter int NPORT = 3,
    parameter int SLOTS = 4,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic                        hold,
    input  logic [NPORT*SLOTS-1:0]      all_valid,
    input  logic [NPORT*SLOTS-1:0]      all_dirty,
    input  logic [NPORT*SLOTS*AW-1:0]   all_addr,
    input  logic [NPORT*SLOTS*DW-1:0]   all_data,
    output logic [NPORT-1:0]            upd_en,
    output logic [AW-1:0]               upd_addr,
    output logic [DW-1:0]               upd_data,
    output logic [NPORT-1:0]            clr_en,
    output logic [$clog2(SLOTS)-1:0]    clr_slot,
    output logic                        st_we,
    output logic [AW-1:0]               st_addr,
    output logic [DW-1:0]               st_data
);
    localparam int NE = NPORT * SLOTS;
    localparam int SW = $clog2(SLOTS);

    int            src, src_idx, src_port, tgt;
    logic          src_found;
    logic [AW-1:0] src_addr;
    logic [DW-1:0] src_data;
    logic [NPORT-1:0] mism;

    // Source selection, mismatch search and action choice.
    always_comb begin
        src = -1;
        for (int k = NE-1; k >= 0; k--) begin
            if (all_valid[k] && all_dirty[k]) src = k;
        end
        src_found = (src >= 0);
        src_idx   = src_found ? src : 0;
        src_port  = src_idx / SLOTS;
        src_addr  = all_addr[src_idx*AW +: AW];
        src_data  = all_data[src_idx*DW +: DW];
        clr_slot  = SW'(src_idx % SLOTS);

        mism = '0;
        for (int j = 0; j < NPORT; j++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (j != src_port && all_valid[j*SLOTS+s] &&
                    all_addr[(j*SLOTS+s)*AW +: AW] == src_addr &&
                    (all_data[(j*SLOTS+s)*DW +: DW] != src_data ||
                     all_dirty[j*SLOTS+s]))
                    mism[j] = 1'b1;
            end
        end
        tgt = -1;
        for (int j = NPORT-1; j >= 0; j--) begin
            if (mism[j]) tgt = j;
        end

        upd_en   = '0;
        clr_en   = '0;
        st_we    = 1'b0;
        upd_addr = src_addr;
        upd_data = src_data;
        st_addr  = src_addr;
        st_data  = src_data;
        if (src_found && !hold) begin
            if (tgt >= 0) begin
                upd_en[tgt] = 1'b1;
            end else begin
                st_we          = 1'b1;
                clr_en[src_port] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_update_array.sv
// Top: per-port request decode, caches, store, propagation engine and the
// barrier/unlock gating.
// Assumes: a read or write is accepted when valid and ready are both high;
// read data is combinational in the accepting cycle.
module coh_update_array
    import coh_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int SLOTS = 4,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORT-1:0]     req_valid,
    input  logic [2*NPORT-1:0]   req_op,
    input  logic [AW*NPORT-1:0]  req_addr,
    input  logic [DW*NPORT-1:0]  req_wdata,
    output logic [NPORT-1:0]     req_ready,
    output logic [DW*NPORT-1:0]  rsp_rdata
);
    localparam int NE = NPORT * SLOTS;
    localparam int SW = $clog2(SLOTS);

    logic [(1<<AW)*DW-1:0] mem_flat;
    logic [NE-1:0]         all_valid, all_dirty;
    logic [NE*AW-1:0]      all_addr;
    logic [NE*DW-1:0]      all_data;
    logic [NPORT-1:0]      hit, wr_room, fill_room, any_dirty;
    logic [NPORT-1:0]      wr_en, fill_en, acc_rw;
    logic [NPORT-1:0]      upd_en, clr_en;
    logic [AW-1:0]         upd_addr, st_addr;
    logic [DW-1:0]         upd_data, st_data;
    logic [SW-1:0]         clr_slot;
    logic                  st_we, hold, consistent;
    logic [DW*NPORT-1:0]   hit_data;

    // System consistency: nothing dirty and every copy equals the store.
    always_comb begin
        consistent = 1'b1;
        for (int k = 0; k < NE; k++) begin
            if (all_dirty[k]) consistent = 1'b0;
            if (all_valid[k] &&
                all_data[k*DW +: DW] != mem_flat[all_addr[k*AW +: AW]*DW +: DW])
                consistent = 1'b0;
        end
    end

    assign hold = |acc_rw;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        coh_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] store_word;

        assign op         = coh_op_e'(req_op[p*2 +: 2]);
        assign addr       = req_addr[p*AW +: AW];
        assign store_word = mem_flat[addr*DW +: DW];

        // Ready per op and the resulting cache enables.
        always_comb begin
            unique case (op)
                OP_READ:    req_ready[p] = 1'b1;
                OP_WRITE:   req_ready[p] = wr_room[p];
                OP_BARRIER: req_ready[p] = consistent;
                default:    req_ready[p] = !any_dirty[p];
            endcase
            wr_en[p]   = req_valid[p] && op == OP_WRITE && wr_room[p];
            fill_en[p] = req_valid[p] && op == OP_READ && !hit[p] && fill_room[p];
            acc_rw[p]  = req_valid[p] && req_ready[p] &&
                         (op == OP_READ || op == OP_WRITE);
            rsp_rdata[p*DW +: DW] = hit[p] ? hit_data[p*DW +: DW] : store_word;
        end

        coh_cache_bank #(.SLOTS(SLOTS), .AW(AW), .DW(DW)) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_addr   (addr),
            .lk_wdata  (req_wdata[p*DW +: DW]),
            .lk_fill   (store_word),
            .wr_en     (wr_en[p]),
            .fill_en   (fill_en[p]),
            .upd_en    (upd_en[p]),
            .upd_addr  (upd_addr),
            .upd_data  (upd_data),
            .clr_en    (clr_en[p]),
            .clr_slot  (clr_slot),
            .hit       (hit[p]),
            .hit_data  (hit_data[p*DW +: DW]),
            .wr_room   (wr_room[p]),
            .fill_room (fill_room[p]),
            .any_dirty (any_dirty[p]),
            .e_valid   (all_valid[p*SLOTS +: SLOTS]),
            .e_dirty   (all_dirty[p*SLOTS +: SLOTS]),
            .e_addr    (all_addr[p*SLOTS*AW +: SLOTS*AW]),
            .e_data    (all_data[p*SLOTS*DW +: SLOTS*DW])
        );
    end

    coh_prop_engine #(.NPORT(NPORT), .SLOTS(SLOTS), .AW(AW), .DW(DW)) i_engine (
        .hold      (hold),
        .all_valid (all_valid),
        .all_dirty (all_dirty),
        .all_addr  (all_addr),
        .all_data  (all_data),
        .upd_en    (upd_en),
        .upd_addr  (upd_addr),
        .upd_data  (upd_data),
        .clr_en    (clr_en),
        .clr_slot  (clr_slot),
        .st_we     (st_we),
        .st_addr   (st_addr),
        .st_data   (st_data)
    );

    coh_store #(.AW(AW), .DW(DW)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (st_we),
        .waddr    (st_addr),
        .wdata    (st_data),
        .mem_flat (mem_flat)
    );
endmodule

// File: rtl/coh_update_array_chk.sv
// Assertion checker for the coherent cache array, bound to the top module.
// Assumes: it observes the top's internal engine and cache summary signals.
module coh_update_array_chk
    import coh_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        req_valid,
    input logic [2*NPORT-1:0]      req_op,
    input logic [NPORT-1:0]        req_ready,
    input logic [NPORT-1:0]        any_dirty,
    input logic [NPORT-1:0]        acc_rw,
    input logic [NPORT-1:0]        upd_en,
    input logic                    st_we,
    input logic [(1<<AW)*DW-1:0]   mem_flat
);
    // R6: one engine action at most per cycle.
    a_r6_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({upd_en, st_we}));

    // R8: accepted processor traffic freezes the engine.
    a_r8_engine_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|acc_rw) |-> (upd_en == '0 && !st_we));

    // R6: the store changes only after a store write by the engine.
    a_r6_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_we) |-> $stable(mem_flat));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R9: a granted barrier sees no dirty entry anywhere.
        a_r9_barrier_clean: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_op[p*2 +: 2] == OP_BARRIER && req_ready[p])
            |-> (any_dirty == '0));

        // R10: a granted unlock sees no dirty entry in its own cache.
        a_r10_unlock_local: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_op[p*2 +: 2] == OP_UNLOCK && req_ready[p])
            |-> !any_dirty[p]);

        // R11: reads never stall.
        a_r11_read_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_op[p*2 +: 2] == OP_READ) |-> req_ready[p]);
    end
endmodule

bind coh_update_array coh_update_array_chk #(.NPORT(NPORT), .AW(AW), .DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .any_dirty (any_dirty),
    .acc_rw    (acc_rw),
    .upd_en    (upd_en),
    .st_we     (st_we),
    .mem_flat  (mem_flat)
);

// File: tb/test_coh_update_array.sv
// Bench: behavioural reference of caches, engine and store, compared each clock.
module test_coh_update_array;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int NS = 4;
    localparam int AW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req_valid;
    logic [2*NP-1:0]  req_op;
    logic [AW*NP-1:0] req_addr;
    logic [DW*NP-1:0] req_wdata;
    logic [NP-1:0]    req_ready;
    logic [DW*NP-1:0] rsp_rdata;

    bit          tv [NP];
    int          top_ [NP];
    int          tad [NP];
    logic [7:0]  twd [NP];

    bit          mval [NP][NS];
    bit          mdir [NP][NS];
    int          madr [NP][NS];
    logic [7:0]  mdat [NP][NS];
    logic [7:0]  mst  [16];

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack the per-port stimulus onto the flat ports.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            req_valid[p]         = tv[p];
            req_op[p*2 +: 2]     = 2'(top_[p]);
            req_addr[p*AW +: AW] = 4'(tad[p]);
            req_wdata[p*DW +: DW] = twd[p];
        end
    end

    coh_update_array #(.NPORT(NP), .SLOTS(NS), .AW(AW), .DW(DW)) i_coh_update_array (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata)
    );

    function automatic int m_hit(int p, int a);
        for (int s = 0; s < NS; s++) if (mval[p][s] && madr[p][s] == a) return s;
        return -1;
    endfunction
    function automatic int m_free(int p);
        for (int s = 0; s < NS; s++) if (!mval[p][s]) return s;
        return -1;
    endfunction
    function automatic int m_clean(int p);
        for (int s = 0; s < NS; s++) if (mval[p][s] && !mdir[p][s]) return s;
        return -1;
    endfunction
    function automatic bit m_dirty(int p);
        for (int s = 0; s < NS; s++) if (mdir[p][s]) return 1'b1;
        return 1'b0;
    endfunction
    function automatic bit m_consistent();
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < NS; s++) begin
                if (mdir[p][s]) return 1'b0;
                if (mval[p][s] && mdat[p][s] != mst[madr[p][s]]) return 1'b0;
            end
        return 1'b1;
    endfunction
    function automatic bit m_ready(int p);
        case (top_[p])
            0: return 1'b1;
            1: return (m_hit(p, tad[p]) >= 0) || (m_free(p) >= 0) || (m_clean(p) >= 0);
            2: return m_consistent();
            default: return !m_dirty(p);
        endcase
    endfunction
    function automatic logic [7:0] m_rdata(int p);
        int h;
        h = m_hit(p, tad[p]);
        return (h >= 0) ? mdat[p][h] : mst[tad[p]];
    endfunction

    // Advance the reference by one clock.
    task automatic m_update();
        bit acc [NP];
        bit anyrw;
        int h, s, sp, ss, tgt, ts, a;
        logic [7:0] d;
        anyrw = 1'b0;
        for (int p = 0; p < NP; p++) begin
            acc[p] = tv[p] && m_ready(p);
            if (acc[p] && top_[p] <= 1) anyrw = 1'b1;
        end
        for (int p = 0; p < NP; p++) begin
            if (acc[p] && top_[p] == 0) begin
                h = m_hit(p, tad[p]);
                s = m_free(p);
                if (h < 0 && s >= 0) begin
                    mval[p][s] = 1'b1; mdir[p][s] = 1'b0;
                    madr[p][s] = tad[p]; mdat[p][s] = mst[tad[p]];
                end
            end else if (acc[p] && top_[p] == 1) begin
                h = m_hit(p, tad[p]);
                s = (h >= 0) ? h : ((m_free(p) >= 0) ? m_free(p) : m_clean(p));
                mval[p][s] = 1'b1; mdir[p][s] = 1'b1;
                madr[p][s] = tad[p]; mdat[p][s] = twd[p];
            end
        end
        if (!anyrw) begin
            sp = -1; ss = 0;
            for (int p = 0; p < NP; p++)
                for (int q = 0; q < NS; q++)
                    if (sp < 0 && mval[p][q] && mdir[p][q]) begin sp = p; ss = q; end
            if (sp >= 0) begin
                a = madr[sp][ss]; d = mdat[sp][ss];
                tgt = -1; ts = 0;
                for (int j = 0; j < NP; j++)
                    for (int q = 0; q < NS; q++)
                        if (tgt < 0 && j != sp && mval[j][q] && madr[j][q] == a &&
                            (mdat[j][q] != d || mdir[j][q])) begin tgt = j; ts = q; end
                if (tgt >= 0) begin
                    mdat[tgt][ts] = d; mdir[tgt][ts] = 1'b0;
                end else begin
                    mst[a] = d; mdir[sp][ss] = 1'b0;
                end
            end
        end
    endtask

    // Compare one cycle's outputs against the reference, then clock both.
    task automatic step(string tag);
        #1;
        for (int p = 0; p < NP; p++) begin
            if (tv[p]) begin
                vectors++;
                if (req_ready[p] !== m_ready(p)) begin
                    miscompares++;
                    $display("FAIL %s port %0d op %0d ready act=%0b exp=%0b",
                             tag, p, top_[p], req_ready[p], m_ready(p));
                end
                if (top_[p] == 0) begin
                    vectors++;
                    if (rsp_rdata[p*DW +: DW] !== m_rdata(p)) begin
                        miscompares++;
                        $display("FAIL %s port %0d read addr %0d act=%0h exp=%0h",
                                 tag, p, tad[p], rsp_rdata[p*DW +: DW], m_rdata(p));
                    end
                end
            end
        end
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic put(int p, bit v, int o, int a, logic [7:0] d);
        tv[p] = v; top_[p] = o; tad[p] = a; twd[p] = d;
    endtask
    task automatic idle_all();
        for (int p = 0; p < NP; p++) put(p, 1'b0, 0, 0, 8'h00);
    endtask
    // Exact-value check at the ports, independent of the model.
    task automatic expect_read(string tag, int p, logic [7:0] exp);
        #1;
        vectors++;
        if (rsp_rdata[p*DW +: DW] !== exp) begin
            miscompares++;
            $display("FAIL %s port %0d direct read act=%0h exp=%0h",
                     tag, p, rsp_rdata[p*DW +: DW], exp);
        end
    endtask
    task automatic expect_ready(string tag, int p, bit exp);
        #1;
        vectors++;
        if (req_ready[p] !== exp) begin
            miscompares++;
            $display("FAIL %s port %0d direct ready act=%0b exp=%0b",
                     tag, p, req_ready[p], exp);
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < NS; s++) begin
                mval[p][s] = 0; mdir[p][s] = 0; madr[p][s] = 0; mdat[p][s] = 0;
            end
        for (int i = 0; i < 16; i++) mst[i] = 8'h00;
        idle_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty caches, zero store, sync requests free.
        put(0, 1, 0, 3, 0); put(1, 1, 2, 0, 0); put(2, 1, 3, 0, 0);
        expect_read("R1", 0, 8'h00); expect_ready("R1", 1, 1'b1);
        step("R1");

        // R2/R4: write on port0 while port1 misses the same address.
        put(0, 1, 1, 1, 8'h11); put(1, 1, 0, 1, 0); put(2, 0, 0, 0, 0);
        expect_read("R4", 1, 8'h00);
        step("R2");
        // R3: own read sees new value, port1's clean hit is stale; R8 holds engine.
        put(0, 1, 0, 1, 0); put(1, 1, 0, 1, 0); put(2, 1, 2, 0, 0);
        expect_read("R2", 0, 8'h11); expect_read("R3", 1, 8'h00);
        expect_ready("R9", 2, 1'b0);
        step("R3");
        put(0, 1, 3, 0, 0); put(1, 1, 0, 1, 0); put(2, 1, 3, 0, 0);
        expect_ready("R10", 0, 1'b0); expect_ready("R10", 2, 1'b1);
        step("R8");
        // R6: idle cycles, engine updates port1 then writes the store.
        put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0); put(2, 1, 2, 0, 0);
        step("R6");
        step("R6");
        expect_ready("R9", 2, 1'b1);
        step("R9");
        put(2, 1, 0, 1, 0);
        expect_read("R6", 2, 8'h11);
        step("R6");

        // R5: fill port0 with dirty entries while port1 reads hold the engine.
        put(1, 1, 0, 1, 0); put(2, 0, 0, 0, 0);
        for (int a = 4; a <= 7; a++) begin
            put(0, 1, 1, a, 8'(8'h40 + a));
            step("R5");
        end
        put(0, 1, 1, 8, 8'h48);
        expect_ready("R5", 0, 1'b0);
        step("R5");
        step("R5");
        put(1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step("R5");
        idle_all();
        for (int i = 0; i < 30; i++) step("R6");

        // R7: same-cycle conflicting writes; lower port wins.
        put(0, 1, 1, 2, 8'hA0); put(2, 1, 1, 2, 8'hB0);
        step("R7");
        idle_all();
        for (int i = 0; i < 10; i++) step("R7");
        put(0, 1, 0, 2, 0); put(2, 1, 0, 2, 0);
        expect_read("R7", 0, 8'hA0); expect_read("R7", 2, 8'hA0);
        step("R7");

        // Random traffic over a few shared addresses (R11 ready on reads).
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < NP; p++)
                put(p, ($urandom % 4) != 0, int'($urandom % 4),
                    int'($urandom % 6), 8'($urandom));
            step("R11");
        end
        idle_all();
        for (int i = 0; i < 40; i++) step("R9");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule